// File: doc/BRIEF.md
# String Primitive Repeat Sequencer

This block carries out one string primitive at a time: block move, element compare, accumulator scan, accumulator load and accumulator store. Each primitive works on a byte or on a word. The caller presents the opcode, an optional repeat prefix byte, the two index pointers, the count register, the accumulator, the direction flag and the incoming zero flag, then pulses `start`. The sequencer performs each iteration through a single request/acknowledge memory port. The port carries an offset address and a one-bit segment tag: 0 selects the source segment and 1 selects the destination segment. After each iteration the sequencer steps the pointers and, under a repeat prefix, counts the count register down.

A five-state iteration loop (source read, destination read, write, update, finish) visits only the states the primitive needs. Compare and scan rewrite the zero flag from the equality of their two operands. Under a repeat prefix they can end before the count runs out, according to that flag. When the run ends, `done` pulses for one cycle. The final pointers, count, accumulator and zero flag remain on the outputs until the next start.

Top module: `strseq_top`

## Requirements
- R1: After reset, `done` and `mem_req` are 0 and every register output is 0. Each `done` pulse lasts exactly one cycle.
- R2: Opcodes A4h/A5h (move) read the source segment (tag 0) at the source pointer, then write the read data to the destination segment (tag 1) at the destination pointer. Opcode bit 0 selects word (1) or byte (0).
- R3: Opcodes ACh/ADh (load) read the source segment at the source pointer into the accumulator. A byte load replaces only bits 7:0 and keeps bits 15:8.
- R4: Opcodes AAh/ABh (store) write the accumulator to the destination segment at the destination pointer. `mem_be` is 11b for a word and 01b for a byte, and byte data sits on bits 7:0.
- R5: Each pointer the primitive uses moves up when the direction flag is 0 and down when it is 1. The step is 1 for a byte and 2 for a word. Load moves only the source pointer. Store and scan move only the destination pointer.
- R6: With a prefix byte other than F3h or F2h, exactly one iteration runs and the count output equals the count input.
- R7: With prefix F3h or F2h, move, load and store iterate until the count reaches 0, and the count drops by one per iteration. Both prefixes behave the same for these three primitives.
- R8: With prefix F3h or F2h and an initial count of 0, no memory request is made and `done` pulses with every register unchanged.
- R9: Opcodes A6h/A7h (compare) read source then destination and set the zero flag to their equality. Opcodes AEh/AFh (scan) read the destination and set the zero flag to its equality with the accumulator. Byte forms compare bits 7:0 only.
- R10: Under F3h, compare and scan stop after the first iteration that leaves the zero flag 0. That iteration's count decrement and pointer step still take effect.
- R11: Under F2h, compare and scan stop after the first iteration that leaves the zero flag 1. They also stop when the count reaches 0.
- R12: While `mem_req` is high without `mem_ack`, the request, address, segment tag and write enable hold steady into the next cycle.
- R13: A `start` with an opcode outside the ten string opcodes (for example 90h or A8h) is ignored: no memory request and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a primitive when idle |
| opcode | input | 8 | Primitive opcode byte |
| prefix | input | 8 | Repeat prefix byte (F3h, F2h, anything else = none) |
| df | input | 1 | Direction flag: 0 up, 1 down |
| zf_in | input | 1 | Zero flag before the primitive |
| si_in | input | 16 | Initial source pointer |
| di_in | input | 16 | Initial destination pointer |
| cx_in | input | 16 | Initial count |
| acc_in | input | 16 | Initial accumulator |
| mem_req | output | 1 | Memory access request |
| mem_seg | output | 1 | Segment tag: 0 source, 1 destination |
| mem_addr | output | 16 | Byte offset of the access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_be | output | 2 | Byte lane enables |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| si_out | output | 16 | Current source pointer |
| di_out | output | 16 | Current destination pointer |
| cx_out | output | 16 | Current count |
| acc_out | output | 16 | Current accumulator |
| zf_out | output | 1 | Current zero flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is early termination partway through a long repeated compare or scan. That case needs the data in memory to produce exactly one flag flip at a chosen iteration. The stimulus writes a matching block into both segments and then plants one differing byte, or one wanted byte, at a known distance from the start pointer. The expected stopping count, pointers and flag then follow from that position. Both directions are covered, and the acknowledge latency varies between runs so that held requests occur.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

    localparam logic [7:0] PFX_WHILE_EQ = 8'hF3;
    localparam logic [7:0] PFX_WHILE_NE = 8'hF2;

    typedef enum logic [2:0] {
        OPK_MOVE,
        OPK_CMP,
        OPK_STORE,
        OPK_LOAD,
        OPK_SCAN
    } opk_t;

    typedef enum logic [1:0] {
        RPT_NONE,
        RPT_EQ,
        RPT_NE
    } rpt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RSRC,
        ST_RDST,
        ST_WR,
        ST_UPD,
        ST_FIN
    } st_t;

    // first memory state that a primitive needs
    function automatic st_t first_access(opk_t k);
        case (k)
            OPK_MOVE, OPK_CMP, OPK_LOAD: return ST_RSRC;
            OPK_SCAN:                    return ST_RDST;
            default:                     return ST_WR;
        endcase
    endfunction

endpackage

// File: rtl/strseq_decode.sv
module strseq_decode
    import strseq_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] prefix,
    output logic       valid,
    output logic       is_word,
    output opk_t       kind,
    output rpt_t       rpt
);

    always_comb begin
        is_word = opcode[0];
        valid   = 1'b1;
        kind    = OPK_MOVE;
        if (opcode[7:4] != 4'hA) begin
            valid = 1'b0;
        end else begin
            case (opcode[3:1])
                3'b010:  kind = OPK_MOVE;
                3'b011:  kind = OPK_CMP;
                3'b101:  kind = OPK_STORE;
                3'b110:  kind = OPK_LOAD;
                3'b111:  kind = OPK_SCAN;
                default: valid = 1'b0;
            endcase
        end
    end

    always_comb begin
        if (prefix == PFX_WHILE_EQ)      rpt = RPT_EQ;
        else if (prefix == PFX_WHILE_NE) rpt = RPT_NE;
        else                             rpt = RPT_NONE;
    end

endmodule

// File: rtl/strseq_idx.sv
module strseq_idx #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic          df,
    input  logic          word,
    input  logic          en,
    output logic [AW-1:0] nxt
);

    localparam int WBYTES = DW / 8;

    logic [AW-1:0] step;

    assign step = word ? AW'(WBYTES) : AW'(1);

    always_comb begin
        if (!en)     nxt = ptr;
        else if (df) nxt = ptr - step;
        else         nxt = ptr + step;
    end

endmodule

// File: rtl/strseq_eq.sv
module strseq_eq #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          word,
    output logic          eq
);

    always_comb begin
        if (word) eq = (a == b);
        else      eq = (a[7:0] == b[7:0]);
    end

endmodule

// File: rtl/strseq_top.sv
module strseq_top
    import strseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [7:0]    prefix,
    input  logic          df,
    input  logic          zf_in,
    input  logic [AW-1:0] si_in,
    input  logic [AW-1:0] di_in,
    input  logic [CW-1:0] cx_in,
    input  logic [DW-1:0] acc_in,
    output logic          mem_req,
    output logic          mem_seg,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic [AW-1:0] si_out,
    output logic [AW-1:0] di_out,
    output logic [CW-1:0] cx_out,
    output logic [DW-1:0] acc_out,
    output logic          zf_out,
    output logic          done
);

    localparam int BW = DW / 8;

    typedef struct packed {
        st_t           st;
        opk_t          kind;
        rpt_t          rpt;
        logic          word;
        logic          df;
        logic [AW-1:0] si;
        logic [AW-1:0] di;
        logic [CW-1:0] cx;
        logic [DW-1:0] acc;
        logic [DW-1:0] src;
        logic          zf;
    } ctx_t;

    ctx_t q, d;

    logic          dec_valid, dec_word;
    opk_t          dec_kind;
    rpt_t          dec_rpt;
    logic [AW-1:0] si_nxt, di_nxt;
    logic          si_en, di_en;
    logic [DW-1:0] cmp_a;
    logic          cmp_eq;
    logic [CW-1:0] cx_dec;
    logic          is_test, halt;

    strseq_decode u_dec (
        .opcode  (opcode),
        .prefix  (prefix),
        .valid   (dec_valid),
        .is_word (dec_word),
        .kind    (dec_kind),
        .rpt     (dec_rpt)
    );

    // the source pointer serves move, compare and load; the destination pointer all but load
    assign si_en = (q.kind == OPK_MOVE) || (q.kind == OPK_CMP) || (q.kind == OPK_LOAD);
    assign di_en = (q.kind != OPK_LOAD);

    strseq_idx #(.AW(AW), .DW(DW)) u_si (
        .ptr (q.si), .df (q.df), .word (q.word), .en (si_en), .nxt (si_nxt)
    );

    strseq_idx #(.AW(AW), .DW(DW)) u_di (
        .ptr (q.di), .df (q.df), .word (q.word), .en (di_en), .nxt (di_nxt)
    );

    assign cmp_a = (q.kind == OPK_CMP) ? q.src : q.acc;

    strseq_eq #(.DW(DW)) u_eq (
        .a (cmp_a), .b (mem_rdata), .word (q.word), .eq (cmp_eq)
    );

    // termination after the count step
    assign cx_dec  = q.cx - CW'(1);
    assign is_test = (q.kind == OPK_CMP) || (q.kind == OPK_SCAN);
    always_comb begin
        halt = 1'b0;
        if (q.rpt == RPT_NONE)                  halt = 1'b1;
        else if (cx_dec == '0)                  halt = 1'b1;
        else if (is_test && q.rpt == RPT_EQ && !q.zf) halt = 1'b1;
        else if (is_test && q.rpt == RPT_NE && q.zf)  halt = 1'b1;
    end

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start && dec_valid) begin
                    d.kind = dec_kind;
                    d.word = dec_word;
                    d.rpt  = dec_rpt;
                    d.df   = df;
                    d.si   = si_in;
                    d.di   = di_in;
                    d.cx   = cx_in;
                    d.acc  = acc_in;
                    d.zf   = zf_in;
                    if (dec_rpt != RPT_NONE && cx_in == '0) d.st = ST_FIN;
                    else                                    d.st = first_access(dec_kind);
                end
            end
            ST_RSRC: begin
                if (mem_ack) begin
                    d.src = mem_rdata;
                    if (q.kind == OPK_LOAD) begin
                        if (q.word) d.acc = mem_rdata;
                        else        d.acc = {q.acc[DW-1:8], mem_rdata[7:0]};
                        d.st = ST_UPD;
                    end else if (q.kind == OPK_CMP) begin
                        d.st = ST_RDST;
                    end else begin
                        d.st = ST_WR;
                    end
                end
            end
            ST_RDST: begin
                if (mem_ack) begin
                    d.zf = cmp_eq;
                    d.st = ST_UPD;
                end
            end
            ST_WR: begin
                if (mem_ack) d.st = ST_UPD;
            end
            ST_UPD: begin
                d.si = si_nxt;
                d.di = di_nxt;
                if (q.rpt != RPT_NONE) d.cx = cx_dec;
                if (halt) d.st = ST_FIN;
                else      d.st = first_access(q.kind);
            end
            ST_FIN: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, kind: OPK_MOVE, rpt: RPT_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_req   = (q.st == ST_RSRC) || (q.st == ST_RDST) || (q.st == ST_WR);
    assign mem_seg   = (q.st != ST_RSRC);
    assign mem_addr  = (q.st == ST_RSRC) ? q.si : q.di;
    assign mem_we    = (q.st == ST_WR);
    assign mem_be    = q.word ? {BW{1'b1}} : BW'(1);
    assign mem_wdata = (q.kind == OPK_MOVE) ? q.src : q.acc;

    assign si_out  = q.si;
    assign di_out  = q.di;
    assign cx_out  = q.cx;
    assign acc_out = q.acc;
    assign zf_out  = q.zf;
    assign done    = (q.st == ST_FIN);

    // R1: completion is a single-cycle pulse
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a run without prefix leaves the count alone
    a_r6_cx_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_UPD && q.rpt == RPT_NONE) |=> (q.cx == $past(q.cx)));

    // R7: a repeated run only loops on while the count is nonzero
    a_r7_loop_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_UPD && q.rpt != RPT_NONE) |=> (q.st == ST_FIN || q.cx != '0));

    // R8: repeat with zero count finishes without touching memory
    a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start && dec_valid && dec_rpt != RPT_NONE && cx_in == '0)
        |=> (done && !mem_req));

    // R12: an unanswered request holds steady
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_seg) && $stable(mem_we)));

    // R13: an unknown opcode leaves the sequencer idle
    a_r13_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start && !dec_valid) |=> (!mem_req && !done));

endmodule

// File: tb/sim_strseq_top.sv
`timescale 1ns/1ps
module sim_strseq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00, prefix = 8'h00;
    logic        df = 1'b0, zf_in = 1'b0;
    logic [15:0] si_in = '0, di_in = '0, cx_in = '0, acc_in = '0;
    logic        mem_req, mem_seg, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [15:0] si_out, di_out, cx_out, acc_out;
    logic        zf_out, done;

    always #2 clk = ~clk;

    strseq_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .prefix(prefix),
        .df(df), .zf_in(zf_in), .si_in(si_in), .di_in(di_in), .cx_in(cx_in), .acc_in(acc_in),
        .mem_req(mem_req), .mem_seg(mem_seg), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .si_out(si_out), .di_out(di_out), .cx_out(cx_out), .acc_out(acc_out),
        .zf_out(zf_out), .done(done)
    );

    typedef struct {
        logic [15:0] si, di, cx, acc;
        logic        zf;
        int          hs;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   total = 0, bad = 0;
    int   hs_total = 0, hs_base = 0;
    int   lat = 0, ack_cnt = 0;
    bit   finished = 0;

    logic [7:0] ds_mem [256];
    logic [7:0] es_mem [256];
    logic [7:0] ref_es [256];
    logic [7:0] a0, a1;

    assign a0 = mem_addr[7:0];
    assign a1 = a0 + 8'd1;
    assign mem_rdata = mem_seg ? {es_mem[a1], es_mem[a0]} : {ds_mem[a1], ds_mem[a0]};

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // memory responder with adjustable latency
    always @(negedge clk) begin
        if (!mem_req) begin
            mem_ack = 1'b0;
            ack_cnt = 0;
        end else if (mem_ack && lat != 0) begin
            mem_ack = 1'b0;
            ack_cnt = 1;
        end else begin
            mem_ack = (ack_cnt >= lat);
            ack_cnt++;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            hs_total <= hs_total + 1;
            if (mem_we && mem_seg) begin
                es_mem[a0] <= mem_wdata[7:0];
                if (mem_be[1]) es_mem[a1] <= mem_wdata[15:8];
            end
        end
    end

    // monitor: pop the expected item at each completion
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check("R13", "unexpected done", 32'd1, 32'd0);
            end else begin
                e = sb.pop_front();
                check(e.tag, "si", 32'(si_out), 32'(e.si));
                check(e.tag, "di", 32'(di_out), 32'(e.di));
                check(e.tag, "cx", 32'(cx_out), 32'(e.cx));
                check(e.tag, "acc", 32'(acc_out), 32'(e.acc));
                check(e.tag, "zf", 32'(zf_out), 32'(e.zf));
                check(e.tag, "accesses", 32'(hs_total - hs_base), 32'(e.hs));
            end
        end
    end

    function automatic logic [15:0] rd_ds(logic [15:0] a, logic w);
        logic [7:0] i = a[7:0];
        return {w ? ds_mem[i + 8'd1] : 8'h00, ds_mem[i]};
    endfunction

    function automatic logic [15:0] rd_ref(logic [15:0] a, logic w);
        logic [7:0] i = a[7:0];
        return {w ? ref_es[i + 8'd1] : 8'h00, ref_es[i]};
    endfunction

    task automatic wr_ref(logic [15:0] a, logic w, logic [15:0] v);
        logic [7:0] i = a[7:0];
        ref_es[i] = v[7:0];
        if (w) ref_es[i + 8'd1] = v[15:8];
    endtask

    // reference model built from the requirements
    task automatic model(logic [7:0] op, logic [7:0] pfx, logic [15:0] si0, logic [15:0] di0,
                         logic [15:0] cx0, logic [15:0] acc0, logic dfl, logic zf0, string tag);
        exp_t e;
        logic [15:0] si = si0, di = di0, cx = cx0, acc = acc0, s = '0, t = '0, st;
        logic zf = zf0, w = op[0], rep, test;
        int k, n = 0;
        case (op & 8'hFE)
            8'hA4: k = 0;
            8'hA6: k = 1;
            8'hAA: k = 2;
            8'hAC: k = 3;
            8'hAE: k = 4;
            default: k = -1;
        endcase
        rep  = (pfx == 8'hF3) || (pfx == 8'hF2);
        test = (k == 1) || (k == 4);
        st   = w ? 16'd2 : 16'd1;
        for (int i = 0; i < 256; i++) ref_es[i] = es_mem[i];
        if (!(rep && cx == 0)) begin
            forever begin
                if (k == 0 || k == 1 || k == 3) begin s = rd_ds(si, w); n++; end
                if (k == 1 || k == 4) begin t = rd_ref(di, w); n++; end
                if (k == 0) begin wr_ref(di, w, s); n++; end
                if (k == 2) begin wr_ref(di, w, acc); n++; end
                if (k == 3) acc = w ? s : {acc[15:8], s[7:0]};
                if (k == 1) zf = w ? (s == t) : (s[7:0] == t[7:0]);
                if (k == 4) zf = w ? (acc == t) : (acc[7:0] == t[7:0]);
                if (k == 0 || k == 1 || k == 3) si = dfl ? si - st : si + st;
                if (k != 3) di = dfl ? di - st : di + st;
                if (rep) cx = cx - 16'd1;
                if (!rep || cx == 0 || (test && pfx == 8'hF3 && !zf) || (test && pfx == 8'hF2 && zf))
                    break;
            end
        end
        e.si = si; e.di = di; e.cx = cx; e.acc = acc; e.zf = zf; e.hs = n; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic run(logic [7:0] op, logic [7:0] pfx, logic [15:0] si, logic [15:0] di,
                       logic [15:0] cx, logic [15:0] acc, logic dfl, logic zf, string tag);
        int g = 0, miss = 0;
        model(op, pfx, si, di, cx, acc, dfl, zf, tag);
        @(negedge clk);
        hs_base = hs_total;
        opcode = op; prefix = pfx; si_in = si; di_in = di; cx_in = cx;
        acc_in = acc; df = dfl; zf_in = zf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && g < 2000) begin @(negedge clk); g++; end
        @(negedge clk);
        for (int i = 0; i < 256; i++) if (es_mem[i] !== ref_es[i]) miss++;
        check(tag, "destination memory mismatches", 32'(miss), 32'd0);
    endtask

    task automatic run_bad(logic [7:0] op);
        @(negedge clk);
        hs_base = hs_total;
        opcode = op; prefix = 8'hF3; cx_in = 16'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        check("R13", "accesses after unknown opcode", 32'(hs_total - hs_base), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R1 watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            finished = 1;
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ds_mem[i] = 8'(i * 37 + 5);
            es_mem[i] = 8'(i * 11 + 200);
        end
        // compare block: equal except the fourth element
        for (int i = 0; i < 16; i++) es_mem[8'h40 + i] = ds_mem[8'h10 + i];
        es_mem[8'h43] = ~ds_mem[8'h13];
        // fully equal block
        for (int i = 0; i < 8; i++) es_mem[8'h90 + i] = ds_mem[8'h80 + i];
        // scan region with a single wanted byte
        for (int i = 0; i < 16; i++) es_mem[8'h60 + i] = 8'(8'h30 + i);
        es_mem[8'h65] = 8'h5A;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "mem_req", 32'(mem_req), 32'd0);
        check("R1", "si", 32'(si_out), 32'd0);
        check("R1", "cx", 32'(cx_out), 32'd0);
        check("R1", "zf", 32'(zf_out), 32'd0);
        rst_n = 1'b1;

        lat = 0;
        run(8'hA4, 8'h00, 16'h0020, 16'h00A0, 16'd7, 16'h0000, 1'b0, 1'b0, "R2");   // byte move up
        run(8'hA5, 8'h00, 16'h0030, 16'h00B0, 16'd7, 16'h0000, 1'b1, 1'b1, "R6");   // word move down
        run(8'hAC, 8'h00, 16'h0005, 16'h0000, 16'd2, 16'hBEEF, 1'b0, 1'b0, "R3");   // byte load keeps high
        run(8'hAD, 8'h00, 16'h0008, 16'h0000, 16'd2, 16'hBEEF, 1'b1, 1'b0, "R5");   // word load down
        lat = 1;
        run(8'hAB, 8'hF3, 16'h0000, 16'h00C0, 16'd4, 16'h1234, 1'b0, 1'b0, "R4");   // repeated word store
        run(8'hAA, 8'hF3, 16'h0000, 16'h00D0, 16'd0, 16'h0077, 1'b0, 1'b1, "R8");   // zero count
        lat = 2;
        run(8'hA4, 8'hF3, 16'h0058, 16'h00E8, 16'd5, 16'h0000, 1'b1, 1'b0, "R7");   // repeated byte move down
        run(8'hA5, 8'hF2, 16'h0070, 16'h0020, 16'd3, 16'h0000, 1'b0, 1'b0, "R7");   // F2 acts as F3
        lat = 1;
        run(8'hA6, 8'hF3, 16'h0010, 16'h0040, 16'd10, 16'h0000, 1'b0, 1'b1, "R10"); // early stop on mismatch
        run(8'hA6, 8'hF3, 16'h0080, 16'h0090, 16'd4, 16'h0000, 1'b0, 1'b0, "R9");   // count exhausted, equal
        run(8'hAE, 8'hF2, 16'h0000, 16'h0060, 16'd20, 16'h005A, 1'b0, 1'b0, "R11"); // scan finds byte
        run(8'hAE, 8'hF2, 16'h0000, 16'h006A, 16'd20, 16'h005A, 1'b1, 1'b0, "R11"); // scan down
        run(8'hAE, 8'hF2, 16'h0000, 16'h0068, 16'd3, 16'h005A, 1'b0, 1'b0, "R11");  // count runs out
        lat = 0;
        run(8'hA7, 8'h00, 16'h0012, 16'h0042, 16'd9, 16'h0000, 1'b0, 1'b1, "R9");   // word compare mismatch
        run(8'hAF, 8'hF3, 16'h0000, 16'h0010, 16'd0, 16'h0000, 1'b1, 1'b0, "R8");   // zero count keeps zf
        run(8'hAF, 8'hF3, 16'h0000, 16'h0092, 16'd2, 16'h0000, 1'b0, 1'b0, "R10");  // word scan mismatch first
        run_bad(8'h90);
        run_bad(8'hA8);
        check("R13", "leftover expected items", 32'(sb.size()), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule